// File: doc/BRIEF.md
# Keyboard Debug Command Controller

This block sits behind a UART receiver and turns single keystrokes into adjustments of two debug settings. It holds a signed phase offset, counted in steps of 1/255 of a clock period, and a 4-bit number that selects an output interference pattern. Each accepted phase change also sends one increment or decrement pulse to an external fine phase shifter. The shifter answers with a completion pulse.

After every accepted change the block reports the new value as ASCII text to a UART transmitter over a ready/valid byte interface. Phase values are shown as two hexadecimal digits. A negative phase is shown as its magnitude in parentheses. The receive side uses a ready signal, so keystrokes are held off while a report is going out or while a phase step is still outstanding.

A command that would take a setting past its limit gets no pulse and no text. The same is true of any byte that is not one of the four command keys.

Top module: `keycmd_ctrl`

## Requirements
- R1: After reset the phase offset is 0, the pattern is 0, tx_valid, ps_inc and ps_dec are low, and rx_ready is high.
- R2: A byte 0x77 ('w') accepted on the receive side raises the phase offset by one, and 0x73 ('s') lowers it by one. Each accepted phase command drives exactly one single-cycle pulse: ps_inc for a raise, ps_dec for a lower. The pulse and the new value appear in the cycle after the accepting clock edge.
- R3: The phase offset stays within -255 to +255. A raise at +255 or a lower at -255 is ignored: the value is unchanged, there is no pulse and no report, and rx_ready stays high.
- R4: After an accepted phase change the report is two uppercase hexadecimal digits of the magnitude, most significant first, followed by CR (0x0D) and LF (0x0A). A negative value is sent as '(' (0x28), the two digits, and ')' (0x29) before CR LF. Zero is sent as "00". The first character is valid in the cycle after the accepting edge.
- R5: A byte 0x64 ('d') raises the pattern number by one and 0x61 ('a') lowers it by one. The range is 0 to 15. A raise at 15 or a lower at 0 is ignored, with no report.
- R6: After an accepted pattern change the report is one uppercase hexadecimal digit followed by CR LF.
- R7: Any other byte, including upper-case letters, changes nothing, produces no pulse and no report, and leaves rx_ready high.
- R8: After an accepted phase command, rx_ready stays low until ps_done has been sampled high after the pulse and the report has finished.
- R9: While a report is being sent, rx_ready is low. tx_valid and tx_data hold while tx_ready is low, and one character moves per clock edge with tx_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block can take a byte this cycle |
| tx_valid | output | 1 | Report character present |
| tx_data | output | 8 | Report character (ASCII) |
| tx_ready | input | 1 | Transmitter takes the character at this edge |
| ps_inc | output | 1 | One-cycle raise pulse to the phase shifter |
| ps_dec | output | 1 | One-cycle lower pulse to the phase shifter |
| ps_done | input | 1 | Phase shifter finished the last step |
| phase_o | output | 9 | Current signed phase offset |
| pattern_o | output | 4 | Current interference pattern number |

## Verification
A byte is accepted at the clock edge where rx_valid and rx_ready are both high. One register stage later, the step pulse, the new setting and the first report character are all present together. The bench drives on falling edges and samples on the falling edge right after the accepting edge, so the pulse is seen in the only cycle it exists. It then reads one report character per falling edge while tx_ready is high, and checks that rx_ready comes back one edge after the last character and the sampled ps_done. Rejected bytes are given four full cycles to show any pulse, character or change of setting before the settings are compared.

// File: rtl/keycmd_pkg.sv
package keycmd_pkg;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_PH_UP  = 3'd1,
        CMD_PH_DN  = 3'd2,
        CMD_PAT_UP = 3'd3,
        CMD_PAT_DN = 3'd4
    } cmd_e;

    typedef enum logic {
        RPT_PAT   = 1'b0,
        RPT_PHASE = 1'b1
    } rpt_e;

    localparam logic [7:0] ASC_CR   = 8'h0D;
    localparam logic [7:0] ASC_LF   = 8'h0A;
    localparam logic [7:0] ASC_LPAR = 8'h28;
    localparam logic [7:0] ASC_RPAR = 8'h29;

    function automatic logic [7:0] hex_ascii(input logic [3:0] nib);
        if (nib < 4'd10) return 8'h30 + {4'h0, nib};
        else             return 8'h37 + {4'h0, nib};
    endfunction

endpackage

// File: rtl/keycmd_decode.sv
module keycmd_decode
    import keycmd_pkg::*;
#(
    parameter logic [7:0] KEY_PH_UP  = 8'h77,
    parameter logic [7:0] KEY_PH_DN  = 8'h73,
    parameter logic [7:0] KEY_PAT_UP = 8'h64,
    parameter logic [7:0] KEY_PAT_DN = 8'h61
) (
    input  logic [7:0] byte_i,
    output cmd_e       cmd_o
);

    always_comb begin
        if      (byte_i == KEY_PH_UP)  cmd_o = CMD_PH_UP;
        else if (byte_i == KEY_PH_DN)  cmd_o = CMD_PH_DN;
        else if (byte_i == KEY_PAT_UP) cmd_o = CMD_PAT_UP;
        else if (byte_i == KEY_PAT_DN) cmd_o = CMD_PAT_DN;
        else                           cmd_o = CMD_NONE;
    end

endmodule

// File: rtl/keycmd_limit.sv
module keycmd_limit
    import keycmd_pkg::*;
#(
    parameter int PHASE_W   = 9,
    parameter int PHASE_LIM = 255,
    parameter int PAT_W     = 4
) (
    input  cmd_e                      cmd_i,
    input  logic signed [PHASE_W-1:0] phase_i,
    input  logic [PAT_W-1:0]          pat_i,
    output logic                      allow_o
);

    localparam logic signed [PHASE_W-1:0] LIM_P = PHASE_W'(PHASE_LIM);
    localparam logic signed [PHASE_W-1:0] LIM_N = -LIM_P;
    localparam logic [PAT_W-1:0]          PAT_TOP = '1;
    localparam logic [PAT_W-1:0]          PAT_BOT = '0;

    always_comb begin
        unique case (cmd_i)
            CMD_PH_UP:  allow_o = (phase_i < LIM_P);
            CMD_PH_DN:  allow_o = (phase_i > LIM_N);
            CMD_PAT_UP: allow_o = (pat_i != PAT_TOP);
            CMD_PAT_DN: allow_o = (pat_i != PAT_BOT);
            default:    allow_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/keycmd_report.sv
module keycmd_report
    import keycmd_pkg::*;
#(
    parameter int PHASE_W = 9,
    parameter int PAT_W   = 4,
    parameter int IDX_W   = 3
) (
    input  rpt_e                      kind_i,
    input  logic [IDX_W-1:0]          idx_i,
    input  logic signed [PHASE_W-1:0] phase_i,
    input  logic [PAT_W-1:0]          pat_i,
    output logic [7:0]                char_o,
    output logic                      last_o
);

    localparam int MAG_W    = PHASE_W - 1;
    localparam int PH_DIG   = (MAG_W + 3) / 4;
    localparam int PH_PADW  = 4 * PH_DIG;
    localparam int PAT_DIG  = (PAT_W + 3) / 4;
    localparam int PAT_PADW = 4 * PAT_DIG;

    logic                neg;
    logic [MAG_W-1:0]    mag;
    logic [PH_PADW-1:0]  mag_pad;
    logic [PH_PADW-1:0]  mag_sh;
    logic [PAT_PADW-1:0] pat_pad;
    logic [PAT_PADW-1:0] pat_sh;
    int                  pos;
    int                  pre;
    int                  k;
    int                  tail;

    always_comb begin
        neg     = phase_i[PHASE_W-1];
        mag     = neg ? MAG_W'(-phase_i) : MAG_W'(phase_i);
        mag_pad = PH_PADW'(mag);
        pat_pad = PAT_PADW'(pat_i);
        pos     = int'(idx_i);
        pre     = neg ? 1 : 0;
        k       = 0;
        tail    = 0;
        mag_sh  = '0;
        pat_sh  = '0;
        char_o  = ASC_LF;
        last_o  = 1'b0;
        if (kind_i == RPT_PHASE) begin
            k = pos - pre;
            if (neg && pos == 0) begin
                char_o = ASC_LPAR;
            end else if (k < PH_DIG) begin
                mag_sh = mag_pad >> (4 * (PH_DIG - 1 - k));
                char_o = hex_ascii(mag_sh[3:0]);
            end else if (neg && k == PH_DIG) begin
                char_o = ASC_RPAR;
            end else begin
                tail = k - PH_DIG - pre;
                if (tail == 0) char_o = ASC_CR;
                else begin
                    char_o = ASC_LF;
                    last_o = 1'b1;
                end
            end
        end else begin
            if (pos < PAT_DIG) begin
                pat_sh = pat_pad >> (4 * (PAT_DIG - 1 - pos));
                char_o = hex_ascii(pat_sh[3:0]);
            end else begin
                tail = pos - PAT_DIG;
                if (tail == 0) char_o = ASC_CR;
                else begin
                    char_o = ASC_LF;
                    last_o = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/keycmd_ctrl.sv
module keycmd_ctrl
    import keycmd_pkg::*;
#(
    parameter int         PHASE_W    = 9,
    parameter int         PHASE_LIM  = 255,
    parameter int         PAT_W      = 4,
    parameter logic [7:0] KEY_PH_UP  = 8'h77,
    parameter logic [7:0] KEY_PH_DN  = 8'h73,
    parameter logic [7:0] KEY_PAT_UP = 8'h64,
    parameter logic [7:0] KEY_PAT_DN = 8'h61
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rx_valid,
    input  logic [7:0]                rx_data,
    output logic                      rx_ready,
    output logic                      tx_valid,
    output logic [7:0]                tx_data,
    input  logic                      tx_ready,
    output logic                      ps_inc,
    output logic                      ps_dec,
    input  logic                      ps_done,
    output logic signed [PHASE_W-1:0] phase_o,
    output logic [PAT_W-1:0]          pattern_o
);

    localparam int RPT_MAX = (PHASE_W - 1 + 3) / 4 + 4;
    localparam int IDX_W   = $clog2(RPT_MAX);
    localparam logic signed [PHASE_W-1:0] STEP = PHASE_W'(1);
    localparam logic [PAT_W-1:0]          PSTEP = PAT_W'(1);

    typedef struct packed {
        logic                      sending;
        rpt_e                      kind;
        logic [IDX_W-1:0]          idx;
        logic                      wait_done;
        logic                      inc;
        logic                      dec;
        logic signed [PHASE_W-1:0] phase;
        logic [PAT_W-1:0]          pat;
    } state_t;

    state_t     s_q, s_d;
    cmd_e       cmd;
    logic       allow;
    logic [7:0] rpt_char;
    logic       rpt_last;
    logic       rdy;

    keycmd_decode #(
        .KEY_PH_UP (KEY_PH_UP),
        .KEY_PH_DN (KEY_PH_DN),
        .KEY_PAT_UP(KEY_PAT_UP),
        .KEY_PAT_DN(KEY_PAT_DN)
    ) decode_i (
        .byte_i(rx_data),
        .cmd_o (cmd)
    );

    keycmd_limit #(
        .PHASE_W  (PHASE_W),
        .PHASE_LIM(PHASE_LIM),
        .PAT_W    (PAT_W)
    ) limit_i (
        .cmd_i  (cmd),
        .phase_i(s_q.phase),
        .pat_i  (s_q.pat),
        .allow_o(allow)
    );

    keycmd_report #(
        .PHASE_W(PHASE_W),
        .PAT_W  (PAT_W),
        .IDX_W  (IDX_W)
    ) report_i (
        .kind_i (s_q.kind),
        .idx_i  (s_q.idx),
        .phase_i(s_q.phase),
        .pat_i  (s_q.pat),
        .char_o (rpt_char),
        .last_o (rpt_last)
    );

    always_comb begin
        rdy       = !s_q.sending && !s_q.wait_done;
        s_d       = s_q;
        s_d.inc   = 1'b0;
        s_d.dec   = 1'b0;

        if (s_q.wait_done && ps_done) s_d.wait_done = 1'b0;

        if (s_q.sending && tx_ready) begin
            if (rpt_last) begin
                s_d.sending = 1'b0;
                s_d.idx     = '0;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end

        if (rx_valid && rdy && allow) begin
            s_d.sending = 1'b1;
            s_d.idx     = '0;
            unique case (cmd)
                CMD_PH_UP: begin
                    s_d.phase     = s_q.phase + STEP;
                    s_d.inc       = 1'b1;
                    s_d.wait_done = 1'b1;
                    s_d.kind      = RPT_PHASE;
                end
                CMD_PH_DN: begin
                    s_d.phase     = s_q.phase - STEP;
                    s_d.dec       = 1'b1;
                    s_d.wait_done = 1'b1;
                    s_d.kind      = RPT_PHASE;
                end
                CMD_PAT_UP: begin
                    s_d.pat  = s_q.pat + PSTEP;
                    s_d.kind = RPT_PAT;
                end
                CMD_PAT_DN: begin
                    s_d.pat  = s_q.pat - PSTEP;
                    s_d.kind = RPT_PAT;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rx_ready  = rdy;
    assign tx_valid  = s_q.sending;
    assign tx_data   = rpt_char;
    assign ps_inc    = s_q.inc;
    assign ps_dec    = s_q.dec;
    assign phase_o   = s_q.phase;
    assign pattern_o = s_q.pat;

endmodule

// File: rtl/keycmd_chk.sv
module keycmd_chk #(
    parameter int PHASE_W   = 9,
    parameter int PHASE_LIM = 255,
    parameter int PAT_W     = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      rx_ready,
    input logic                      tx_valid,
    input logic [7:0]                tx_data,
    input logic                      tx_ready,
    input logic                      ps_inc,
    input logic                      ps_dec,
    input logic signed [PHASE_W-1:0] phase_o,
    input logic [PAT_W-1:0]          pattern_o
);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_inc || ps_dec) |=> !(ps_inc || ps_dec)); // R2

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ps_inc, ps_dec})); // R2

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ps_inc |-> (int'(phase_o) == int'($past(phase_o)) + 1)); // R2

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ps_dec |-> (int'(phase_o) == int'($past(phase_o)) - 1)); // R2

    AST_PHASE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_o) |-> (ps_inc || ps_dec)); // R2

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(phase_o) <= PHASE_LIM) && (int'(phase_o) >= -PHASE_LIM)); // R3

    AST_PHASE_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_inc || ps_dec) |-> tx_valid); // R4

    AST_PAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pattern_o) |-> (tx_valid &&
            ((int'(pattern_o) == int'($past(pattern_o)) + 1) ||
             (int'(pattern_o) == int'($past(pattern_o)) - 1)))); // R5

    AST_STEP_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_inc || ps_dec) |-> !rx_ready); // R8

    AST_BUSY_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !rx_ready); // R9

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R9

endmodule

bind keycmd_ctrl keycmd_chk #(
    .PHASE_W  (PHASE_W),
    .PHASE_LIM(PHASE_LIM),
    .PAT_W    (PAT_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_ready (rx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .ps_inc   (ps_inc),
    .ps_dec   (ps_dec),
    .phase_o  (phase_o),
    .pattern_o(pattern_o)
);

// File: tb/keycmd_ctrl_tb_top.sv
module keycmd_ctrl_tb_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_data = 8'h00;
    logic              rx_ready;
    logic              tx_valid;
    logic [7:0]        tx_data;
    logic              tx_ready = 1'b1;
    logic              ps_inc;
    logic              ps_dec;
    logic              ps_done = 1'b0;
    logic signed [8:0] phase_o;
    logic [3:0]        pattern_o;

    always #4 clk = ~clk;

    keycmd_ctrl dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_ready (rx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .ps_inc   (ps_inc),
        .ps_dec   (ps_dec),
        .ps_done  (ps_done),
        .phase_o  (phase_o),
        .pattern_o(pattern_o)
    );

    int checks = 0;
    int fails  = 0;
    int inc_cnt = 0, dec_cnt = 0, txv_cnt = 0, run = 0, run_max = 0;
    int exp_buf [8];
    int exp_len = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ps_inc) inc_cnt++;
            if (ps_dec) dec_cnt++;
            if (tx_valid) txv_cnt++;
            if (ps_inc || ps_dec) run++;
            else run = 0;
            if (run > run_max) run_max = run;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int hexc(input int n);
        return (n < 10) ? 48 + n : 55 + n;
    endfunction

    task automatic build_exp(input bit is_phase, input int v);
        int m;
        exp_len = 0;
        if (is_phase) begin
            m = (v < 0) ? -v : v;
            if (v < 0) begin exp_buf[exp_len] = 40; exp_len++; end
            exp_buf[exp_len] = hexc(m / 16); exp_len++;
            exp_buf[exp_len] = hexc(m % 16); exp_len++;
            if (v < 0) begin exp_buf[exp_len] = 41; exp_len++; end
        end else begin
            exp_buf[exp_len] = hexc(v); exp_len++;
        end
        exp_buf[exp_len] = 13; exp_len++;
        exp_buf[exp_len] = 10; exp_len++;
    endtask

    task automatic run_cmd(input logic [7:0] key, input bit acc, input int eph,
                           input int epat, input string req);
        int  inc0, dec0, tx0, got, bad, first_bad, first_exp;
        bit  is_phase;
        is_phase = (key == 8'h77) || (key == 8'h73);
        inc0 = inc_cnt; dec0 = dec_cnt; tx0 = txv_cnt;
        @(negedge clk);
        chk(rx_ready == 1'b1, req, "rx_ready before byte", int'(rx_ready), 1);
        rx_valid = 1'b1; rx_data = key;
        @(negedge clk);
        rx_valid = 1'b0;
        if (acc) begin
            chk(ps_inc == (key == 8'h77 && is_phase), "R2", "ps_inc after accept",
                int'(ps_inc), int'(key == 8'h77 && is_phase));
            chk(ps_dec == (key == 8'h73), "R2", "ps_dec after accept",
                int'(ps_dec), int'(key == 8'h73));
            build_exp(is_phase, is_phase ? eph : epat);
            got = 0; bad = 0; first_bad = 0; first_exp = 0;
            while (tx_valid && got < 8) begin
                if (got < exp_len && int'(tx_data) != exp_buf[got]) begin
                    if (bad == 0) begin first_bad = int'(tx_data); first_exp = exp_buf[got]; end
                    bad++;
                end
                got++;
                @(negedge clk);
            end
            chk(got == exp_len, is_phase ? "R4" : "R6", "report length", got, exp_len);
            chk(bad == 0, is_phase ? "R4" : "R6", "report character", first_bad, first_exp);
            if (is_phase) begin
                chk(inc_cnt - inc0 == int'(key == 8'h77), "R2", "inc pulses",
                    inc_cnt - inc0, int'(key == 8'h77));
                chk(dec_cnt - dec0 == int'(key == 8'h73), "R2", "dec pulses",
                    dec_cnt - dec0, int'(key == 8'h73));
                chk(run_max == 1, "R2", "pulse width", run_max, 1);
                chk(rx_ready == 1'b0, "R8", "held off before done", int'(rx_ready), 0);
                ps_done = 1'b1;
                @(negedge clk);
                ps_done = 1'b0;
                chk(rx_ready == 1'b1, "R8", "ready after done", int'(rx_ready), 1);
            end else begin
                chk(inc_cnt == inc0 && dec_cnt == dec0, "R5", "no pulse on pattern",
                    inc_cnt - inc0 + dec_cnt - dec0, 0);
                chk(rx_ready == 1'b1, "R9", "ready after report", int'(rx_ready), 1);
            end
        end else begin
            repeat (4) @(negedge clk);
            chk(txv_cnt == tx0, req, "no report for ignored byte", txv_cnt - tx0, 0);
            chk(inc_cnt == inc0 && dec_cnt == dec0, req, "no pulse for ignored byte",
                inc_cnt - inc0 + dec_cnt - dec0, 0);
            chk(rx_ready == 1'b1, req, "ready stays high", int'(rx_ready), 1);
        end
        chk(int'(phase_o) == eph, req, "phase value", int'(phase_o), eph);
        chk(int'(pattern_o) == epat, req, "pattern value", int'(pattern_o), epat);
    endtask

    typedef struct packed {
        logic [7:0] key;
        logic       acc;
        int         ph;
        int         pat;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'h77, 1'b1,  1, 0},
        '{8'h77, 1'b1,  2, 0},
        '{8'h73, 1'b1,  1, 0},
        '{8'h73, 1'b1,  0, 0},
        '{8'h73, 1'b1, -1, 0},
        '{8'h64, 1'b1, -1, 1},
        '{8'h64, 1'b1, -1, 2},
        '{8'h61, 1'b1, -1, 1},
        '{8'h78, 1'b0, -1, 1},
        '{8'h61, 1'b1, -1, 0},
        '{8'h61, 1'b0, -1, 0},
        '{8'h57, 1'b0, -1, 0}
    };

    function automatic string tag_of(input logic [7:0] key, input bit acc);
        if (key == 8'h77 || key == 8'h73) return acc ? "R2" : "R3";
        if (key == 8'h64 || key == 8'h61) return "R5";
        return "R7";
    endfunction

    bit finished = 1'b0;

    initial begin
        int c0, nchar, bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(int'(phase_o) == 0, "R1", "phase after reset", int'(phase_o), 0);
        chk(pattern_o == 4'd0, "R1", "pattern after reset", int'(pattern_o), 0);
        chk(!tx_valid && !ps_inc && !ps_dec, "R1", "outputs idle after reset",
            int'({tx_valid, ps_inc, ps_dec}), 0);
        chk(rx_ready == 1'b1, "R1", "rx_ready after reset", int'(rx_ready), 1);

        for (int i = 0; i < NV; i++)
            run_cmd(VECS[i].key, VECS[i].acc, VECS[i].ph, VECS[i].pat,
                    tag_of(VECS[i].key, VECS[i].acc));

        // R3 upper phase limit
        for (int v = 0; v <= 255; v++) run_cmd(8'h77, 1'b1, v, 0, "R2");
        run_cmd(8'h77, 1'b0, 255, 0, "R3");
        // R3 lower phase limit, report "(FF)" at the end (R4)
        for (int v = 254; v >= -255; v--) run_cmd(8'h73, 1'b1, v, 0, "R2");
        run_cmd(8'h73, 1'b0, -255, 0, "R3");

        // R9 back-pressure: report held while tx_ready low, byte held off
        tx_ready = 1'b0;
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h64;
        @(negedge clk);
        rx_valid = 1'b0;
        c0 = int'(tx_data);
        chk(tx_valid == 1'b1, "R9", "tx_valid under back-pressure", int'(tx_valid), 1);
        chk(c0 == 8'h31, "R6", "first pattern digit", c0, 8'h31);
        rx_valid = 1'b1; rx_data = 8'h64;
        bad = 0;
        repeat (3) begin
            @(negedge clk);
            if (!tx_valid || int'(tx_data) != c0 || rx_ready) bad++;
        end
        rx_valid = 1'b0;
        chk(bad == 0, "R9", "hold cycles with stable char and ready low", bad, 0);
        tx_ready = 1'b1;
        nchar = 0;
        while (tx_valid && nchar < 8) begin nchar++; @(negedge clk); end
        chk(nchar == 3, "R9", "characters after release", nchar, 3);
        chk(pattern_o == 4'd1, "R9", "held-off byte not taken", int'(pattern_o), 1);

        // R5 upper pattern limit
        for (int p = 2; p <= 15; p++) run_cmd(8'h64, 1'b1, -255, p, "R5");
        run_cmd(8'h64, 1'b0, -255, 15, "R5");
        run_cmd(8'h0D, 1'b0, -255, 15, "R7");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule